// File: doc/BRIEF.md
# Endpoint0 Control-Status and Interrupt Unit

This unit holds the control/status bits of a USB device's control endpoint and produces the single interrupt line that the processor services. A packet engine feeds it one-cycle strobes: a packet arrived (with an error qualifier), an IN packet went out, the status stage finished, the transaction ended on a protocol violation, or the transfer ended early. Hardware sets or clears status bits from these strobes. Each qualifying strobe also raises a sticky endpoint pending flag.

Four bus-level events (start of frame, bus reset, resume, suspend) set sticky pending flags of their own. Each of these flags is masked by an enable register. The processor reaches everything through a small register port. The endpoint status register is only visible while an index register holds zero. Reading a pending register returns its flags and clears them.

The interrupt line comes from a two-state sequencer. **IRQ_QUIET** is the reset state. It moves to **IRQ_RAISED** on the edge after any request is present, which means the endpoint pending flag or any enabled bus pending flag. **IRQ_RAISED** returns to **IRQ_QUIET** on the edge after every request has been cleared. The output is high exactly while the sequencer is in IRQ_RAISED.

Top module: `ep0_ctrl_irq`

Register addresses on `reg_addr`: 0 index, 1 endpoint status, 2 bus enable, 3 bus pending, 4 endpoint pending. Reads are combinational. Writes and read-clears take effect at the clock edge.

## Requirements
- R1: A write to address 1 changes the endpoint status register only when the index register (address 0) is zero. While the index is non-zero, a read of address 1 returns 0.
- R2: A packet strobe without the error qualifier sets status bit 0 (output ready) and the endpoint pending flag.
- R3: An IN-sent strobe clears status bit 1 (input ready) and sets the endpoint pending flag. Firmware sets bit 1 by writing 1 to it. When the hardware clear and the firmware set fall in the same cycle, the hardware clear wins.
- R4: A status-done strobe clears status bit 3 (data end) and sets the endpoint pending flag. Firmware sets bit 3 by writing 1 to it.
- R5: A protocol-violation strobe sets status bit 2 (sent stall) and the endpoint pending flag.
- R6: An early-end strobe while bit 3 is 0 sets status bit 4 (setup end) and the endpoint pending flag. An early-end strobe while bit 3 is 1 only clears bit 3: bit 4 and the pending flag are left unchanged.
- R7: A packet strobe with the error qualifier set changes no status bit and no pending flag.
- R8: The bus enable register resets to 0x06. Its bit 3 enables start of frame, bit 2 bus reset, bit 1 resume and bit 0 suspend. Bits 7 to 4 read as 0 and ignore writes.
- R9: Bus events set sticky flags in the bus pending register (bit 3 start of frame, bit 2 reset, bit 1 resume, bit 0 suspend). A read of address 3 returns the flags and clears them. An event in the same cycle as the read stays set.
- R10: Firmware clears bit 0 by writing 1 to bit 6, and clears bits 2 and 4 by writing 0 to them. Bit 6 reads 0. A hardware set in the same cycle as a firmware clear leaves the bit set.
- R11: `irq` is 1 on the edge after the endpoint pending flag, or any bus pending flag whose enable bit is 1, is present. It returns to 0 on the edge after none remains.
- R12: A read of address 4 returns the endpoint pending flag in bit 0 and clears it. A new endpoint event in the same cycle as the read stays set.
- R13: After reset the status bits, the index, both pending registers and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pe_rx_pkt | input | 1 | SETUP/OUT packet landed in the endpoint buffer |
| pe_rx_err | input | 1 | Qualifies `pe_rx_pkt`: the packet was corrupt |
| pe_in_sent | input | 1 | IN packet unloaded and sent to the host |
| pe_status_done | input | 1 | Status stage of a control transaction completed |
| pe_proto_err | input | 1 | Transaction ended on a protocol violation |
| pe_early_end | input | 1 | Control transfer ended before its expected end |
| bus_sof | input | 1 | Start-of-frame event |
| bus_reset | input | 1 | Bus reset event |
| bus_resume | input | 1 | Resume event |
| bus_suspend | input | 1 | Suspend event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read-clear) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are collisions. In one, a hardware set lands in the same cycle as a firmware clear. In the other, an event lands in the same cycle as the read that clears its pending flag. The bench reaches both by driving the engine strobe and the register access in the same cycle, and it reads back afterwards to see which one won. The interrupt masking is swept over all 256 pairs of enable value and event pattern. For each pair the bench checks the line against the AND of the two, then checks that it drops one edge after the read-clear.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    localparam int unsigned ADR_INDEX   = 0;
    localparam int unsigned ADR_STATUS  = 1;
    localparam int unsigned ADR_BUS_IE  = 2;
    localparam int unsigned ADR_BUS_PND = 3;
    localparam int unsigned ADR_EP_PND  = 4;

    localparam int unsigned BIT_OUT_RDY = 0;
    localparam int unsigned BIT_IN_RDY  = 1;
    localparam int unsigned BIT_STALL   = 2;
    localparam int unsigned BIT_DEND    = 3;
    localparam int unsigned BIT_SEND    = 4;
    localparam int unsigned BIT_SVC     = 6;
    localparam int unsigned N_STATUS    = 5;

    typedef struct packed {
        logic svc_out;
        logic send_keep;
        logic dend_set;
        logic stall_keep;
        logic inrdy_set;
    } status_wr_t;
endpackage

// File: rtl/ep0_status_regs.sv
module ep0_status_regs
    import ep0_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_rx_ok,
    input  logic                ev_in_sent,
    input  logic                ev_status_done,
    input  logic                ev_proto_err,
    input  logic                ev_early_end,
    input  logic                wr_en,
    input  status_wr_t          wr_bits,
    input  logic                pend_rd,
    output logic [N_STATUS-1:0] status,
    output logic                ep_pend
);
    logic out_rdy_q, in_rdy_q, stall_q, dend_q, send_q;
    logic early_valid;
    logic ep_event;

    assign early_valid = ev_early_end && !dend_q;
    assign ep_event    = ev_rx_ok || ev_in_sent || ev_status_done
                      || ev_proto_err || early_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_rdy_q <= 1'b0;
            in_rdy_q  <= 1'b0;
            stall_q   <= 1'b0;
            dend_q    <= 1'b0;
            send_q    <= 1'b0;
            ep_pend   <= 1'b0;
        end else begin
            if (ev_rx_ok)                            out_rdy_q <= 1'b1;
            else if (wr_en && wr_bits.svc_out)       out_rdy_q <= 1'b0;

            if (ev_in_sent)                          in_rdy_q  <= 1'b0;
            else if (wr_en && wr_bits.inrdy_set)     in_rdy_q  <= 1'b1;

            if (ev_proto_err)                        stall_q   <= 1'b1;
            else if (wr_en && !wr_bits.stall_keep)   stall_q   <= 1'b0;

            if (ev_status_done || ev_early_end)      dend_q    <= 1'b0;
            else if (wr_en && wr_bits.dend_set)      dend_q    <= 1'b1;

            if (early_valid)                         send_q    <= 1'b1;
            else if (wr_en && !wr_bits.send_keep)    send_q    <= 1'b0;

            ep_pend <= ep_event || (ep_pend && !pend_rd);
        end
    end

    always_comb begin
        status              = '0;
        status[BIT_OUT_RDY] = out_rdy_q;
        status[BIT_IN_RDY]  = in_rdy_q;
        status[BIT_STALL]   = stall_q;
        status[BIT_DEND]    = dend_q;
        status[BIT_SEND]    = send_q;
    end

    AST_OUTRDY_ON_RX: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_ok |=> out_rdy_q) else $error("out ready not set");         // R2
    AST_OUTRDY_ONLY_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_rx_ok && !out_rdy_q) |=> !out_rdy_q) else $error("spurious out ready"); // R7
    AST_INRDY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ev_in_sent |=> !in_rdy_q) else $error("in ready not cleared");     // R3
    AST_STALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ev_proto_err |=> stall_q) else $error("stall not set");           // R5
    AST_SEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_early_end && !dend_q) |=> send_q) else $error("setup end not set"); // R6
    AST_EP_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx_ok || ev_in_sent || ev_status_done || ev_proto_err) |=> ep_pend)
        else $error("endpoint pending missing");                          // R12
endmodule

// File: rtl/bus_event_pend.sv
module bus_event_pend #(
    parameter int unsigned      N_EV   = 4,
    parameter logic [N_EV-1:0]  IE_RST = 4'b0110
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EV-1:0] ev,
    input  logic            ie_we,
    input  logic [N_EV-1:0] ie_wdata,
    input  logic            pend_rd,
    output logic [N_EV-1:0] ie,
    output logic [N_EV-1:0] pend,
    output logic            req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ie <= IE_RST;
        else if (ie_we) ie <= ie_wdata;
    end

    for (genvar g = 0; g < N_EV; g++) begin : g_pend
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend[g] <= 1'b0;
            else        pend[g] <= ev[g] || (pend[g] && !pend_rd);
        end

        AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            ev[g] |=> pend[g]) else $error("bus event lost");             // R9
    end

    assign req = |(pend & ie);

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_rd && ev == '0) |=> pend == '0) else $error("read-clear failed"); // R9
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
    import ep0_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_ep,
    input  logic req_bus,
    output logic irq
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (req_ep || req_bus)   state_d = IRQ_RAISED;
            IRQ_RAISED: if (!req_ep && !req_bus) state_d = IRQ_QUIET;
            default:                             state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end
endmodule

// File: rtl/ep0_ctrl_irq.sv
module ep0_ctrl_irq
    import ep0_pkg::*;
#(
    parameter int unsigned DW   = 8,
    parameter int unsigned AW   = 4,
    parameter int unsigned N_EV = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pe_rx_pkt,
    input  logic          pe_rx_err,
    input  logic          pe_in_sent,
    input  logic          pe_status_done,
    input  logic          pe_proto_err,
    input  logic          pe_early_end,
    input  logic          bus_sof,
    input  logic          bus_reset,
    input  logic          bus_resume,
    input  logic          bus_suspend,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    localparam int unsigned PAD_ST = DW - N_STATUS;
    localparam int unsigned PAD_EV = DW - N_EV;

    logic [DW-1:0]       index_q;
    logic                index_zero;
    logic                sel_index, sel_status, sel_ie, sel_bpnd, sel_epnd;
    logic                status_we;
    status_wr_t          status_wr;
    logic [N_STATUS-1:0] status;
    logic                ep_pend;
    logic [N_EV-1:0]     bus_ev, bus_ie, bus_pend;
    logic                bus_req;
    logic                rx_ok;

    assign sel_index  = (reg_addr == AW'(ADR_INDEX));
    assign sel_status = (reg_addr == AW'(ADR_STATUS));
    assign sel_ie     = (reg_addr == AW'(ADR_BUS_IE));
    assign sel_bpnd   = (reg_addr == AW'(ADR_BUS_PND));
    assign sel_epnd   = (reg_addr == AW'(ADR_EP_PND));

    assign index_zero = (index_q == '0);
    assign status_we  = reg_wr && sel_status && index_zero;
    assign rx_ok      = pe_rx_pkt && !pe_rx_err;
    assign bus_ev     = {bus_sof, bus_reset, bus_resume, bus_suspend};

    always_comb begin
        status_wr.svc_out    = reg_wdata[BIT_SVC];
        status_wr.send_keep  = reg_wdata[BIT_SEND];
        status_wr.dend_set   = reg_wdata[BIT_DEND];
        status_wr.stall_keep = reg_wdata[BIT_STALL];
        status_wr.inrdy_set  = reg_wdata[BIT_IN_RDY];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  index_q <= '0;
        else if (reg_wr && sel_index) index_q <= reg_wdata;
    end

    ep0_status_regs u_status (
        .clk            (clk),
        .rst_n          (rst_n),
        .ev_rx_ok       (rx_ok),
        .ev_in_sent     (pe_in_sent),
        .ev_status_done (pe_status_done),
        .ev_proto_err   (pe_proto_err),
        .ev_early_end   (pe_early_end),
        .wr_en          (status_we),
        .wr_bits        (status_wr),
        .pend_rd        (reg_rd && sel_epnd),
        .status         (status),
        .ep_pend        (ep_pend)
    );

    bus_event_pend #(
        .N_EV   (N_EV),
        .IE_RST (N_EV'(6))
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (bus_ev),
        .ie_we    (reg_wr && sel_ie),
        .ie_wdata (reg_wdata[N_EV-1:0]),
        .pend_rd  (reg_rd && sel_bpnd),
        .ie       (bus_ie),
        .pend     (bus_pend),
        .req      (bus_req)
    );

    irq_sequencer u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_ep  (ep_pend),
        .req_bus (bus_req),
        .irq     (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel_index)                     reg_rdata = index_q;
        else if (sel_status && index_zero) reg_rdata = {{PAD_ST{1'b0}}, status};
        else if (sel_ie)                   reg_rdata = {{PAD_EV{1'b0}}, bus_ie};
        else if (sel_bpnd)                 reg_rdata = {{PAD_EV{1'b0}}, bus_pend};
        else if (sel_epnd)                 reg_rdata = {{(DW-1){1'b0}}, ep_pend};
    end

    AST_IRQ_FOLLOWS_EP: assert property (@(posedge clk) disable iff (!rst_n)
        ep_pend |=> irq) else $error("irq missing for endpoint");        // R11
    AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ep_pend && (bus_pend & bus_ie) == '0) |=> !irq) else $error("irq stuck"); // R11
    AST_STATUS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!index_zero && !rx_ok && !pe_in_sent && !pe_status_done && !pe_proto_err
         && !pe_early_end) |=> $stable(status)) else $error("status changed"); // R1
endmodule

// File: tb/ep0_ctrl_irq_bench.sv
`timescale 1ns/1ps
module ep0_ctrl_irq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pe_rx_pkt = 0, pe_rx_err = 0, pe_in_sent = 0, pe_status_done = 0;
    logic       pe_proto_err = 0, pe_early_end = 0;
    logic       bus_sof = 0, bus_reset = 0, bus_resume = 0, bus_suspend = 0;
    logic       reg_wr = 0, reg_rd = 0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    ep0_ctrl_irq u_ep0_ctrl_irq (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    // v = {rx, err, in_sent, status_done, proto, early}
    task automatic pe(input logic [5:0] v);
        @(negedge clk);
        {pe_rx_pkt, pe_rx_err, pe_in_sent, pe_status_done, pe_proto_err, pe_early_end} = v;
        @(negedge clk);
        {pe_rx_pkt, pe_rx_err, pe_in_sent, pe_status_done, pe_proto_err, pe_early_end} = '0;
    endtask

    task automatic bus(input logic [3:0] v);
        @(negedge clk); {bus_sof, bus_reset, bus_resume, bus_suspend} = v;
        @(negedge clk); {bus_sof, bus_reset, bus_resume, bus_suspend} = '0;
    endtask

    task automatic chk_irq(input string req, input logic exp);
        @(negedge clk); #1 check(req, {7'd0, irq}, {7'd0, exp});
    endtask

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R13 / R8 reset state
        #1 check("R13 irq", {7'd0, irq}, 8'h00);
        rd(4'd1, d); check("R13 status", d, 8'h00);
        rd(4'd0, d); check("R13 index", d, 8'h00);
        rd(4'd3, d); check("R13 bus pend", d, 8'h00);
        rd(4'd4, d); check("R13 ep pend", d, 8'h00);
        rd(4'd2, d); check("R8 enable reset", d, 8'h06);

        // R8 upper bits ignored
        for (int i = 0; i < 16; i++) begin
            wr(4'd2, 8'(i * 17));
            rd(4'd2, d); check("R8 enable write", d, 8'(i));
        end
        wr(4'd2, 8'h00);

        // R2 / R12 / R11
        pe(6'b100000);
        chk_irq("R11 raise ep", 1'b1);
        rd(4'd1, d); check("R2 out ready", d, 8'h01);
        rd(4'd4, d); check("R12 ep pend read", d, 8'h01);
        chk_irq("R11 drop ep", 1'b0);
        rd(4'd4, d); check("R12 ep pend cleared", d, 8'h00);

        // R10 serviced bit clears out ready, reads 0
        wr(4'd1, 8'h54);
        rd(4'd1, d); check("R10 serviced clear", d, 8'h00);
        // R10 collision: rx and serviced write same cycle
        @(negedge clk); reg_wr = 1; reg_addr = 4'd1; reg_wdata = 8'h54; pe_rx_pkt = 1;
        @(negedge clk); reg_wr = 0; pe_rx_pkt = 0;
        rd(4'd1, d); check("R10 hw set wins", d, 8'h01);
        wr(4'd1, 8'h54);
        rd(4'd4, d);

        // R7 errored packet
        pe(6'b110000);
        rd(4'd1, d); check("R7 no status", d, 8'h00);
        rd(4'd4, d); check("R7 no pending", d, 8'h00);
        chk_irq("R7 no irq", 1'b0);

        // R3
        wr(4'd1, 8'h16);
        rd(4'd1, d); check("R3 fw set in ready", d, 8'h02);
        pe(6'b001000);
        rd(4'd1, d); check("R3 in ready cleared", d, 8'h00);
        rd(4'd4, d); check("R3 ep pend", d, 8'h01);
        // R3 collision: hw clear wins over fw set
        wr(4'd1, 8'h16);
        @(negedge clk); reg_wr = 1; reg_addr = 4'd1; reg_wdata = 8'h16; pe_in_sent = 1;
        @(negedge clk); reg_wr = 0; pe_in_sent = 0;
        rd(4'd1, d); check("R3 hw clear wins", d, 8'h00);
        rd(4'd4, d);

        // R5 and R10 clear by writing 0
        pe(6'b000010);
        rd(4'd1, d); check("R5 stall set", d, 8'h04);
        rd(4'd4, d); check("R5 ep pend", d, 8'h01);
        wr(4'd1, 8'h10);
        rd(4'd1, d); check("R10 stall cleared", d, 8'h00);
        @(negedge clk); reg_wr = 1; reg_addr = 4'd1; reg_wdata = 8'h00; pe_proto_err = 1;
        @(negedge clk); reg_wr = 0; pe_proto_err = 0;
        rd(4'd1, d); check("R10 stall hw wins", d, 8'h04);
        wr(4'd1, 8'h00);
        rd(4'd4, d);

        // R6
        pe(6'b000001);
        rd(4'd1, d); check("R6 setup end set", d, 8'h10);
        rd(4'd4, d); check("R6 ep pend", d, 8'h01);
        wr(4'd1, 8'h08);
        rd(4'd1, d); check("R6 R10 setup end cleared, data end set", d, 8'h08);
        pe(6'b000001);
        rd(4'd1, d); check("R6 late end no setup end", d, 8'h00);
        rd(4'd4, d); check("R6 late end no pend", d, 8'h00);

        // R4
        wr(4'd1, 8'h08);
        pe(6'b000100);
        rd(4'd1, d); check("R4 data end cleared", d, 8'h00);
        rd(4'd4, d); check("R4 ep pend", d, 8'h01);

        // R1 index gating
        wr(4'd1, 8'h16);
        for (int i = 1; i < 16; i++) begin
            wr(4'd0, 8'(i));
            wr(4'd1, 8'h4A);
            rd(4'd1, d); check("R1 hidden read", d, 8'h00);
        end
        wr(4'd0, 8'h00);
        rd(4'd1, d); check("R1 unchanged", d, 8'h02);
        pe(6'b001000);
        rd(4'd4, d);

        // R9 / R11 sweep
        for (int ie = 0; ie < 16; ie++) begin
            wr(4'd2, 8'(ie));
            for (int ev = 0; ev < 16; ev++) begin
                bus(4'(ev));
                chk_irq("R11 masked irq", ((ie & ev) != 0));
                rd(4'd3, d); check("R9 pend read", d, 8'(ev));
                chk_irq("R11 irq drop", 1'b0);
                rd(4'd3, d); check("R9 pend cleared", d, 8'h00);
            end
        end

        // R9 event during read stays set
        wr(4'd2, 8'h00);
        @(negedge clk); reg_rd = 1; reg_addr = 4'd3; bus_sof = 1;
        #1 check("R9 old value during read", reg_rdata, 8'h00);
        @(negedge clk); reg_rd = 0; bus_sof = 0;
        rd(4'd3, d); check("R9 set wins", d, 8'h08);

        // R12 event during read stays set
        @(negedge clk); reg_rd = 1; reg_addr = 4'd4; pe_proto_err = 1;
        @(negedge clk); reg_rd = 0; pe_proto_err = 0;
        rd(4'd4, d); check("R12 set wins", d, 8'h01);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule